// File: doc/BRIEF.md
# Multi-channel handshake bus controller

This block lets several logical channels share one byte-wide bus. Each channel has a sending side, which takes a 16-bit message from local logic, and a receiving side, which rebuilds that message. The bus has one START line, one DONE line, a data byte and a channel-ID field. A 16-bit message crosses the bus as two byte transfers. Each byte uses a four-phase handshake: START rises with the data, DONE rises, START falls, then DONE falls.

When more than one sender is waiting, a round-robin arbiter grants the bus to one of them. That sender keeps the bus until both bytes of its message are complete, so transfers from different channels never interleave. A receiver responds only while the ID on the bus equals its own channel number. When the second handshake ends, the receiver pulses a valid flag for one cycle, with the whole word on its output.

Top module: `hs_bus_ctrl`

## Requirements
- R1: After reset, `bus_start`, `bus_done`, `bus_grant` and `rcv_valid` are all low, and `bus_id` and `bus_data` are zero.
- R2: The ID field is ceil(log2 NCH) bits wide (2 bits for 4 channels). While a grant is active, `bus_id` equals the granted channel number and does not change until the message ends.
- R3: A message goes out low byte first: bits 7:0 at the first START rise, then bits 15:8 at the second.
- R4: START rises only while DONE is low. START falls only after DONE has been seen high. DONE rises only while START is high.
- R5: Only the receiver whose channel number equals `bus_id` raises DONE or captures data. The other channels give no valid pulse.
- R6: Once the second byte's DONE has fallen, the receiver of the addressed channel raises `rcv_valid` for exactly one cycle. Its 16-bit `rcv_word` slice then holds the message.
- R7: When several channels are waiting, grants go in round-robin order, starting from the channel after the one served last. Channel 0 is served first after reset. A grant lasts for both bytes of a message.
- R8: `snd_busy[i]` rises in the cycle after a request is accepted and stays high until the message's final DONE-low. A request made while busy is ignored.
- R9: At most one bit of `bus_grant` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | NCH | Per-channel request to send the message presented on `snd_msg` |
| snd_msg | input | NCH*16 | Per-channel 16-bit message, channel i in bits 16i+15:16i |
| snd_busy | output | NCH | Sender holds an unfinished message |
| rcv_valid | output | NCH | One-cycle pulse: channel i received a full word |
| rcv_word | output | NCH*16 | Per-channel assembled word, same slicing as `snd_msg` |
| bus_grant | output | NCH | One-hot owner of the bus |
| bus_id | output | IDW | Channel number of the active transfer |
| bus_data | output | 8 | Data byte on the bus |
| bus_start | output | 1 | Sender strobe |
| bus_done | output | 1 | Receiver acknowledge |

## Verification
The in-RTL assertions check the handshake ordering on every cycle: no START rise while DONE is high, and no DONE rise without START. They also check that the grant is one-hot at most, that the ID holds steady during a grant, and that valid never lasts two cycles. The bench scenarios cover what those per-cycle checks cannot. These are byte order, the correct assembled word at the right receiver, the round-robin sequence under simultaneous requests, and a request made while busy leaving no trace.

// File: rtl/hs_bus_ctrl.sv
module hs_bus_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int MW  = 2 * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     snd_req,
  input  logic [NCH*MW-1:0]  snd_msg,
  output logic [NCH-1:0]     snd_busy,
  output logic [NCH-1:0]     rcv_valid,
  output logic [NCH*MW-1:0]  rcv_word,
  output logic [NCH-1:0]     bus_grant,
  output logic [IDW-1:0]     bus_id,
  output logic [DW-1:0]      bus_data,
  output logic               bus_start,
  output logic               bus_done
);

  typedef enum logic [2:0] {S_IDLE, S_LO_UP, S_LO_DN, S_HI_UP, S_HI_DN} st_t;

  st_t            state;
  logic [NCH-1:0] pend;
  logic [MW-1:0]  hold [NCH];
  logic [IDW-1:0] owner;
  logic [IDW-1:0] rr_last;
  logic [IDW-1:0] pick;
  logic           pick_vld;
  logic [NCH-1:0] r_done;
  logic           finish;

  assign snd_busy = pend;
  assign bus_done = |r_done;
  assign finish   = (state == S_HI_DN) && !bus_done;

  always_comb begin
    pick     = '0;
    pick_vld = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      int idx;
      idx = (int'(rr_last) + 1 + k) % NCH;
      if (!pick_vld && pend[idx]) begin
        pick     = IDW'(idx);
        pick_vld = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_snd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        hold[i] <= '0;
      end else if (!pend[i]) begin
        if (snd_req[i]) begin
          pend[i] <= 1'b1;
          hold[i] <= snd_msg[i*MW +: MW];
        end
      end else if (finish && owner == IDW'(i)) begin
        pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      owner     <= '0;
      rr_last   <= IDW'(NCH - 1);
      bus_grant <= '0;
      bus_id    <= '0;
      bus_data  <= '0;
      bus_start <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pick_vld) begin
          owner     <= pick;
          bus_grant <= NCH'(1) << pick;
          bus_id    <= pick;
          bus_data  <= hold[pick][DW-1:0];
          bus_start <= 1'b1;
          state     <= S_LO_UP;
        end
        S_LO_UP: if (bus_done) begin
          bus_start <= 1'b0;
          state     <= S_LO_DN;
        end
        S_LO_DN: if (!bus_done) begin
          bus_data  <= hold[owner][MW-1:DW];
          bus_start <= 1'b1;
          state     <= S_HI_UP;
        end
        S_HI_UP: if (bus_done) begin
          bus_start <= 1'b0;
          state     <= S_HI_DN;
        end
        S_HI_DN: if (!bus_done) begin
          bus_grant <= '0;
          rr_last   <= owner;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_rcv
    logic          half;
    logic [MW-1:0] word;
    logic          vld;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_done[i] <= 1'b0;
        half      <= 1'b0;
        word      <= '0;
        vld       <= 1'b0;
      end else begin
        vld <= 1'b0;
        if (!r_done[i]) begin
          if (bus_start && bus_id == IDW'(i)) begin
            if (!half) word[DW-1:0]  <= bus_data;
            else       word[MW-1:DW] <= bus_data;
            half      <= ~half;
            r_done[i] <= 1'b1;
          end
        end else if (!bus_start) begin
          r_done[i] <= 1'b0;
          vld       <= !half;
        end
      end
    end

    assign rcv_valid[i]          = vld;
    assign rcv_word[i*MW +: MW]  = word;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld); // R6
    AST_DONE_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(r_done[i]) |-> bus_id == IDW'(i)); // R5
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant)); // R9
  AST_START_AFTER_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_start) |-> !bus_done); // R4
  AST_START_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_start) |-> bus_done); // R4
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_done) |-> bus_start); // R4
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_grant && $past(|bus_grant)) |-> $stable(bus_id)); // R2
  AST_START_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> $countones(bus_grant) == 1); // R7

endmodule

// File: tb/hs_bus_ctrl_tb.sv
module hs_bus_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int IDW = 2;
  localparam int MW  = 16;
  localparam int NV  = 6;

  localparam logic [IDW+MW-1:0] VEC [NV] = '{
    {2'd0, 16'h1234}, {2'd3, 16'hBEEF}, {2'd1, 16'h00FF},
    {2'd2, 16'hFF00}, {2'd3, 16'h0001}, {2'd0, 16'hA55A}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    snd_req = '0;
  logic [NCH*MW-1:0] snd_msg = '0;
  logic [NCH-1:0]    snd_busy, rcv_valid, bus_grant;
  logic [NCH*MW-1:0] rcv_word;
  logic [IDW-1:0]    bus_id;
  logic [DW-1:0]     bus_data;
  logic              bus_start, bus_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [DW-1:0]  log_data [64];
  logic [IDW-1:0] log_id   [64];
  int             nlog = 0;
  logic           p_start = 0, p_done = 0;

  always #5 clk = ~clk;

  hs_bus_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_msg(snd_msg),
    .snd_busy(snd_busy), .rcv_valid(rcv_valid), .rcv_word(rcv_word),
    .bus_grant(bus_grant), .bus_id(bus_id), .bus_data(bus_data),
    .bus_start(bus_start), .bus_done(bus_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_start && !p_start) begin
        if (nlog < 64) begin
          log_data[nlog] = bus_data;
          log_id[nlog]   = bus_id;
          nlog++;
        end
        check(!bus_done, "R4 start rose with done high", 32'(bus_done), 0);
      end
      if (!bus_start && p_start)
        check(bus_done, "R4 start fell before done", 32'(bus_done), 1);
      if (|bus_grant)
        check(bus_grant == (4'b1 << bus_id), "R2 id vs grant",
              32'(bus_grant), 32'(4'b1 << bus_id));
    end
    p_start = bus_start;
    p_done  = bus_done;
  end

  task automatic send(input int ch, input logic [MW-1:0] m);
    @(negedge clk);
    snd_msg[ch*MW +: MW] = m;
    snd_req[ch] = 1'b1;
    @(negedge clk);
    snd_req[ch] = 1'b0;
  endtask

  task automatic wait_valid(output logic [NCH-1:0] v);
    v = '0;
    for (int t = 0; t < 60; t++) begin
      if (|rcv_valid) begin v = rcv_valid; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [NCH-1:0] v;
    int last;
    repeat (3) @(negedge clk);
    check(!bus_start && !bus_done && bus_grant == 0 && rcv_valid == 0,
          "R1 reset controls", {bus_start, bus_done, bus_grant, rcv_valid}, 0);
    check(bus_id == 0 && bus_data == 0, "R1 reset id/data", {bus_id, bus_data}, 0);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      int ch;
      logic [MW-1:0] m;
      ch = int'(VEC[n][IDW+MW-1:MW]);
      m  = VEC[n][MW-1:0];
      nlog = 0;
      send(ch, m);
      check(snd_busy[ch], "R8 busy after accept", 32'(snd_busy), 32'(1 << ch));
      wait_valid(v);
      check(v == (4'b1 << ch), "R5 valid only on addressed channel", 32'(v), 32'(1 << ch));
      check(rcv_word[ch*MW +: MW] == m, "R6 assembled word", rcv_word[ch*MW +: MW], m);
      check(nlog == 2 && log_data[0] == m[7:0] && log_data[1] == m[15:8],
            "R3 byte order", {log_data[0], log_data[1]}, {m[7:0], m[15:8]});
      check(log_id[0] == IDW'(ch) && log_id[1] == IDW'(ch), "R2 id per byte",
            {log_id[0], log_id[1]}, {IDW'(ch), IDW'(ch)});
      @(negedge clk);
      check(rcv_valid == 0, "R6 valid one cycle", 32'(rcv_valid), 0);
      repeat (2) @(negedge clk);
      check(!snd_busy[ch], "R8 busy cleared", 32'(snd_busy), 0);
    end
    last = 0;

    // R8: request while busy is dropped
    send(1, 16'hC0DE);
    @(negedge clk);
    snd_msg[1*MW +: MW] = 16'hDEAD;
    snd_req[1] = 1'b1;
    @(negedge clk);
    snd_req[1] = 1'b0;
    wait_valid(v);
    check(rcv_word[1*MW +: MW] == 16'hC0DE, "R8 first message kept",
          rcv_word[1*MW +: MW], 16'hC0DE);
    @(negedge clk);
    v = '0;
    for (int t = 0; t < 40; t++) begin
      v |= rcv_valid;
      @(negedge clk);
    end
    check(v == 0 && rcv_word[1*MW +: MW] == 16'hC0DE, "R8 busy request ignored",
          {v, rcv_word[1*MW +: MW]}, 16'hC0DE);
    last = 1;

    // R7: all channels request together, order follows the last served (1)
    @(negedge clk);
    for (int c = 0; c < NCH; c++) snd_msg[c*MW +: MW] = MW'(16'h1100 + c);
    snd_req = '1;
    @(negedge clk);
    snd_req = '0;
    for (int k = 0; k < NCH; k++) begin
      int exp_ch;
      exp_ch = (last + 1 + k) % NCH;
      wait_valid(v);
      check(v == (4'b1 << exp_ch), "R7 round-robin order", 32'(v), 32'(1 << exp_ch));
      check(rcv_word[exp_ch*MW +: MW] == MW'(16'h1100 + exp_ch), "R7 word intact",
            rcv_word[exp_ch*MW +: MW], 16'h1100 + exp_ch);
      @(negedge clk);
    end
    check(nlog >= 2, "R4 handshakes seen", nlog, 2);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule